// File: doc/BRIEF.md
# Register-to-EEPROM Profile Sequencer

This block copies selected parts of a sparse control register space into a 512-byte nonvolatile memory (a save) and copies them back (a load). A host fills a 23-byte command list with two kinds of entry. A section group is three bytes long and names a run of consecutive registers. An opcode is one byte and asks for an update strobe, a final stop or a pausing stop. During a save the sequencer walks the list. It writes every list entry into memory, and after each group header it writes the register bytes that the header names. The result is a self-describing stream that a load parses from memory address 0.

A pausing stop hands the register port back to the host while the memory write pointer is kept. The host can then rewrite the list and start another save, which appends to the stream. This lets more groups be stored than one list can describe, and lets the same register be stored more than once. The block raises a sticky error flag when the stream runs past the end of memory, when it meets a malformed entry, or when the list ends without a stop. After each operation it enforces an idle gap before it accepts the next start.

Top module: `nvm_profile_seq`

## Requirements
- R1: After reset, busy, err, paused, upd, nv_we and rf_we are all 0.
- R11: Every command-list byte resets to 0xFF. Writes through buf_we are applied only while busy is 0. A write made while busy is 1 is ignored.
- R2: A save begins at list index 0. A list byte from 0x00 to 0x7F is a group header that holds N-1, so 0x7F means 128 registers. The next two list bytes are the high and low bytes of the 16-bit start address. Each list byte takes one cycle and is written to memory at the write pointer, which then advances by one. Each register byte takes two cycles. In the first, rf_addr is presented. In the second, the data that comes back is written to memory and the register address advances by one.
- R3: Opcode 0x80 takes one memory write during a save and raises no strobe. During a load it drives upd high for exactly one cycle.
- R4: Opcode 0xFF is written to memory during a save and ends the operation. In both directions busy is 0 on the cycle after the one that handles the opcode, and err stays 0.
- R5: During a save, opcode 0xFE is written to memory, ends the save and sets paused. The next save then continues at the held write pointer. A save that starts while paused is 0 begins at memory address 0. A load, or any error, clears paused.
- R6: A load reads memory from address 0 and spends two cycles on each stream byte. Register bytes are written through rf_we to consecutive addresses from the group's start. A 0xFE in the stream ends the load like 0xFF. No memory write occurs during a load, and no register write occurs during a save.
- R7: err is set and the operation ends when a save must write with the pointer at 512, or when a load must read with its pointer at 512.
- R8: err is set and nothing is written when a byte from 0x81 to 0xFD appears where an opcode or header is expected. The same happens for a header whose two address bytes would lie beyond list index 22.
- R9: err is set when a save reaches list index 23 without meeting 0xFF or 0xFE.
- R10: A start is ignored while busy is 1. After an operation ends, the block waits GAP_CYC idle cycles, and a start presented in that window is ignored. A save start takes priority over a load start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_save | input | 1 | Request a save (list to memory) |
| start_load | input | 1 | Request a load (memory to registers) |
| buf_we | input | 1 | Command-list write strobe |
| buf_addr | input | 5 | Command-list index |
| buf_wdata | input | 8 | Command-list byte |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Sticky transfer error, cleared by an accepted start |
| paused | output | 1 | Last save ended on a pausing stop |
| upd | output | 1 | One-cycle bank update strobe during a load |
| rf_addr | output | 16 | Register file address |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | 8 | Register file write data |
| rf_rdata | input | 8 | Register file read data, one cycle after rf_addr |
| nv_addr | output | 9 | Memory address |
| nv_we | output | 1 | Memory write enable |
| nv_wdata | output | 8 | Memory write data |
| nv_rdata | input | 8 | Memory read data, one cycle after nv_addr |

## Verification
The bench keeps the default list length of 23 and the default memory depth of 512. With these values the overflow cases can actually be reached: four maximal groups of 131 stream bytes each run off the end of memory, and a stream of 512 update opcodes runs a load off the end. GAP_CYC is set to 6, so each operation waits only a few cycles and the bench can present a start inside the guard window and see it ignored. The reference model rebuilds the expected per-cycle port activity from the list contents, the bench's own register and memory images and the held write pointer.

// File: rtl/nvm_profile_seq.sv
module nvm_profile_seq #(
  parameter int BUF_LEN  = 23,
  parameter int NV_DEPTH = 512,
  parameter int GAP_CYC  = 1000
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_save,
  input  logic                        start_load,
  input  logic                        buf_we,
  input  logic [$clog2(BUF_LEN)-1:0]  buf_addr,
  input  logic [7:0]                  buf_wdata,
  output logic                        busy,
  output logic                        err,
  output logic                        paused,
  output logic                        upd,
  output logic [15:0]                 rf_addr,
  output logic                        rf_we,
  output logic [7:0]                  rf_wdata,
  input  logic [7:0]                  rf_rdata,
  output logic [$clog2(NV_DEPTH)-1:0] nv_addr,
  output logic                        nv_we,
  output logic [7:0]                  nv_wdata,
  input  logic [7:0]                  nv_rdata
);
  localparam int BW = $clog2(BUF_LEN + 1);
  localparam int AW = $clog2(NV_DEPTH);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [7:0] OP_UPD = 8'h80, OP_END = 8'hFF, OP_PAUSE = 8'hFE;

  typedef enum logic [2:0] {IDLE, S_CMD, S_HDR, S_RD, S_DW, L_RQ, L_GET} st_t;

  st_t            st;
  logic [7:0]     cbuf [BUF_LEN];
  logic [BW-1:0]  bi, hidx;
  logic [AW:0]    nwp, lp;
  logic [6:0]     cnt;
  logic [15:0]    raddr;
  logic [1:0]     k, ph;
  logic [GW-1:0]  gap;
  logic           err_q, held;
  logic [7:0]     cb;
  logic           nv_full, lp_end, cmd_ok, ld_bad, fail;

  assign cb      = (bi < BW'(BUF_LEN)) ? cbuf[bi] : OP_END;
  assign hidx    = bi + BW'(k);
  assign nv_full = (nwp == (AW+1)'(NV_DEPTH));
  assign lp_end  = (lp == (AW+1)'(NV_DEPTH));
  assign cmd_ok  = (bi < BW'(BUF_LEN)) && !nv_full &&
                   (cb == OP_UPD || cb == OP_END || cb == OP_PAUSE ||
                    (!cb[7] && (32'(bi) + 2 < BUF_LEN)));
  assign ld_bad  = nv_rdata[7] && nv_rdata != OP_UPD && nv_rdata != OP_END && nv_rdata != OP_PAUSE;
  assign fail    = (st == S_CMD && !cmd_ok) ||
                   ((st == S_HDR || st == S_DW) && nv_full) ||
                   (st == L_RQ && lp_end) ||
                   (st == L_GET && ph == 2'd0 && ld_bad);

  assign busy     = (st != IDLE);
  assign err      = err_q;
  assign paused   = held;
  assign upd      = (st == L_GET) && (ph == 2'd0) && (nv_rdata == OP_UPD);
  assign rf_addr  = raddr;
  assign rf_we    = (st == L_GET) && (ph == 2'd3);
  assign rf_wdata = nv_rdata;
  assign nv_we    = (st == S_CMD && cmd_ok) || ((st == S_HDR || st == S_DW) && !nv_full);
  assign nv_addr  = (st == L_RQ || st == L_GET) ? lp[AW-1:0] : nwp[AW-1:0];
  assign nv_wdata = (st == S_CMD) ? cb : (st == S_HDR) ? cbuf[hidx] : rf_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; bi <= '0; nwp <= '0; lp <= '0; cnt <= '0; raddr <= '0;
      k <= '0; ph <= '0; gap <= '0; err_q <= 1'b0; held <= 1'b0;
      for (int i = 0; i < BUF_LEN; i++) cbuf[i] <= OP_END;
    end else if (fail) begin
      err_q <= 1'b1; held <= 1'b0; st <= IDLE; gap <= GW'(GAP_CYC);
    end else begin
      case (st)
        IDLE: begin
          if (buf_we && 32'(buf_addr) < BUF_LEN) cbuf[buf_addr] <= buf_wdata;
          if (gap != '0) gap <= gap - 1'b1;
          else if (start_save) begin
            st <= S_CMD; bi <= '0; err_q <= 1'b0; held <= 1'b0;
            if (!held) nwp <= '0;
          end else if (start_load) begin
            st <= L_RQ; lp <= '0; ph <= '0; err_q <= 1'b0; held <= 1'b0;
          end
        end
        S_CMD: begin
          nwp <= nwp + 1'b1;
          if (cb == OP_END || cb == OP_PAUSE) begin
            st <= IDLE; gap <= GW'(GAP_CYC); held <= (cb == OP_PAUSE);
          end else if (cb == OP_UPD) bi <= bi + 1'b1;
          else begin cnt <= cb[6:0]; k <= 2'd1; st <= S_HDR; end
        end
        S_HDR: begin
          nwp <= nwp + 1'b1;
          if (k == 2'd1) begin raddr[15:8] <= cbuf[hidx]; k <= 2'd2; end
          else begin raddr[7:0] <= cbuf[hidx]; bi <= bi + BW'(3); st <= S_RD; end
        end
        S_RD: st <= S_DW;
        S_DW: begin
          nwp <= nwp + 1'b1; raddr <= raddr + 1'b1;
          if (cnt == '0) st <= S_CMD;
          else begin cnt <= cnt - 1'b1; st <= S_RD; end
        end
        L_RQ: st <= L_GET;
        L_GET: begin
          lp <= lp + 1'b1; st <= L_RQ;
          case (ph)
            2'd0: if (nv_rdata == OP_END || nv_rdata == OP_PAUSE) begin
                    st <= IDLE; gap <= GW'(GAP_CYC);
                  end else if (!nv_rdata[7]) begin cnt <= nv_rdata[6:0]; ph <= 2'd1; end
            2'd1: begin raddr[15:8] <= nv_rdata; ph <= 2'd2; end
            2'd2: begin raddr[7:0] <= nv_rdata; ph <= 2'd3; end
            default: begin
              raddr <= raddr + 1'b1;
              if (cnt == '0) ph <= 2'd0; else cnt <= cnt - 1'b1;
            end
          endcase
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_profile_seq_chk.sv
module nvm_profile_seq_chk #(
  parameter int GAP_CYC = 1000
)(
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic err,
  input logic paused,
  input logic upd,
  input logic nv_we,
  input logic rf_we
);
  localparam int GW = $clog2(GAP_CYC + 2);
  logic [GW:0] idle_n;

  always_ff @(posedge clk) begin
    if (!rst_n) idle_n <= (GW+1)'(GAP_CYC + 1);
    else if (busy) idle_n <= '0;
    else if (32'(idle_n) <= GAP_CYC) idle_n <= idle_n + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!nv_we && !rf_we && !upd)); // R4
  AST_ONE_PORT:   assert property (@(posedge clk) disable iff (!rst_n) !(nv_we && rf_we)); // R6
  AST_PAUSE_END:  assert property (@(posedge clk) disable iff (!rst_n) $rose(paused) |-> $fell(busy)); // R5
  AST_ERR_END:    assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> $fell(busy)); // R7
  AST_ERR_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (!busy && $past(!busy)) |-> $stable(err)); // R8
  AST_UPD_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) upd |=> !upd); // R3
  AST_GAP_KEPT:   assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (32'(idle_n) > GAP_CYC)); // R10
endmodule

bind nvm_profile_seq nvm_profile_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .paused(paused),
  .upd(upd), .nv_we(nv_we), .rf_we(rf_we)
);

// File: tb/nvm_profile_seq_tb.sv
module nvm_profile_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 6;
  localparam int BL = 23;

  typedef struct packed {
    logic busy; logic nvwe; logic [8:0] na; logic [7:0] nd;
    logic rfwe; logic [15:0] ra; logic [7:0] rd; logic upd;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic start_save = 0, start_load = 0, buf_we = 0;
  logic [4:0] buf_addr = 0;
  logic [7:0] buf_wdata = 0;
  logic busy, err, paused, upd, rf_we, nv_we;
  logic [15:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata, nv_wdata, nv_rdata;
  logic [8:0] nv_addr;

  logic [7:0] nvm [512];
  logic [7:0] rfm [65536];
  logic bd_nv_we = 0, bd_rf_we = 0;
  logic [8:0] bd_nv_a = 0;
  logic [15:0] bd_rf_a = 0;
  logic [7:0] bd_d = 0;

  ent_t q[$];
  logic [7:0] bufm [BL];
  int nwp_m = 0, checks = 0, errors = 0;
  bit held_m = 0, exp_err = 0, exp_paused = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_profile_seq #(.BUF_LEN(BL), .NV_DEPTH(512), .GAP_CYC(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_save(start_save), .start_load(start_load),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .busy(busy), .err(err), .paused(paused), .upd(upd),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .nv_addr(nv_addr), .nv_we(nv_we), .nv_wdata(nv_wdata), .nv_rdata(nv_rdata));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 65536; i++) rfm[i] <= 8'(i * 7 + 3);
      for (int i = 0; i < 512; i++) nvm[i] <= 8'h00;
    end else begin
      if (nv_we) nvm[nv_addr] <= nv_wdata;
      if (bd_nv_we) nvm[bd_nv_a] <= bd_d;
      if (rf_we) rfm[rf_addr] <= rf_wdata;
      if (bd_rf_we) rfm[bd_rf_a] <= bd_d;
    end
    nv_rdata <= nvm[nv_addr];
    rf_rdata <= rfm[rf_addr];
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void push(bit nvwe, int na, int nd, bit rfwe, int ra, int rd, bit u);
    ent_t e;
    e.busy = 1; e.nvwe = nvwe; e.na = 9'(na); e.nd = 8'(nd);
    e.rfwe = rfwe; e.ra = 16'(ra); e.rd = 8'(rd); e.upd = u;
    q.push_back(e);
  endfunction

  function automatic void build_save();
    int bi = 0, nw = held_m ? nwp_m : 0;
    bit done = 0;
    q.delete(); exp_err = 0; exp_paused = 0;
    while (!done) begin
      if (bi >= BL || nw == 512) begin push(0,0,0,0,0,0,0); exp_err = 1; done = 1; end
      else begin
        logic [7:0] b = bufm[bi];
        if (b == 8'h80) begin push(1,nw,b,0,0,0,0); nw++; bi++; end
        else if (b == 8'hFF || b == 8'hFE) begin
          push(1,nw,b,0,0,0,0); nw++; exp_paused = (b == 8'hFE); done = 1;
        end else if (!b[7] && bi + 2 < BL) begin
          int a = {bufm[bi+1], bufm[bi+2]};
          push(1,nw,b,0,0,0,0); nw++;
          for (int j = 1; j <= 2 && !done; j++) begin
            if (nw == 512) begin push(0,0,0,0,0,0,0); exp_err = 1; done = 1; end
            else begin push(1,nw,bufm[bi+j],0,0,0,0); nw++; end
          end
          for (int j = 0; j <= int'(b) && !done; j++) begin
            push(0,0,0,0,0,0,0);
            if (nw == 512) begin push(0,0,0,0,0,0,0); exp_err = 1; done = 1; end
            else begin push(1,nw,rfm[16'(a)],0,0,0,0); nw++; a++; end
          end
          bi += 3;
        end else begin push(0,0,0,0,0,0,0); exp_err = 1; done = 1; end
      end
    end
    nwp_m = nw; held_m = exp_paused;
  endfunction

  function automatic void build_load();
    int lp = 0, ph = 0, cnt = 0, a = 0;
    bit done = 0;
    q.delete(); exp_err = 0; exp_paused = 0;
    while (!done) begin
      push(0,0,0,0,0,0,0);
      if (lp == 512) begin exp_err = 1; done = 1; end
      else begin
        logic [7:0] d = nvm[lp];
        case (ph)
          0: if (d == 8'h80) push(0,0,0,0,0,0,1);
             else if (d == 8'hFF || d == 8'hFE) begin push(0,0,0,0,0,0,0); done = 1; end
             else if (!d[7]) begin push(0,0,0,0,0,0,0); cnt = d; ph = 1; end
             else begin push(0,0,0,0,0,0,0); exp_err = 1; done = 1; end
          1: begin push(0,0,0,0,0,0,0); a = int'(d) << 8; ph = 2; end
          2: begin push(0,0,0,0,0,0,0); a = a | int'(d); ph = 3; end
          default: begin
            push(0,0,0,1,a,d,0); a++;
            if (cnt == 0) ph = 0; else cnt--;
          end
        endcase
        lp++;
      end
    end
    held_m = 0;
  endfunction

  task automatic run(input bit sv, input string req, input bit inject);
    repeat (GAP + 2) @(negedge clk);
    if (sv) build_save(); else build_load();
    if (sv) start_save = 1; else start_load = 1;
    @(negedge clk);
    start_save = 0; start_load = 0;
    foreach (q[i]) begin
      ent_t e = q[i];
      chk(busy === e.busy, req, "busy", busy, e.busy);
      chk(nv_we === e.nvwe, req, "nv_we", nv_we, e.nvwe);
      if (e.nvwe) begin
        chk(nv_addr === e.na, req, "nv_addr", nv_addr, e.na);
        chk(nv_wdata === e.nd, req, "nv_wdata", nv_wdata, e.nd);
      end
      chk(rf_we === e.rfwe, req, "rf_we", rf_we, e.rfwe);
      if (e.rfwe) begin
        chk(rf_addr === e.ra, req, "rf_addr", rf_addr, e.ra);
        chk(rf_wdata === e.rd, req, "rf_wdata", rf_wdata, e.rd);
      end
      chk(upd === e.upd, req, "upd", upd, e.upd);
      if (inject) begin
        buf_we = (i == 1); buf_addr = 0; buf_wdata = 8'h90;
      end
      @(negedge clk);
    end
    buf_we = 0;
    chk(busy === 1'b0, req, "busy_end", busy, 0);
    chk(err === exp_err, req, "err", err, exp_err);
    chk(paused === exp_paused, req, "paused", paused, exp_paused);
  endtask

  task automatic wbuf(input int idx, input logic [7:0] v);
    buf_we = 1; buf_addr = 5'(idx); buf_wdata = v; bufm[idx] = v;
    @(negedge clk);
    buf_we = 0;
  endtask

  task automatic poke_nv(input int a, input logic [7:0] v);
    bd_nv_we = 1; bd_nv_a = 9'(a); bd_d = v;
    @(negedge clk);
    bd_nv_we = 0;
  endtask

  task automatic poke_rf(input int a, input logic [7:0] v);
    bd_rf_we = 1; bd_rf_a = 16'(a); bd_d = v;
    @(negedge clk);
    bd_rf_we = 0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < BL; i++) bufm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(busy === 0, "R1", "busy", busy, 0);
    chk(err === 0, "R1", "err", err, 0);
    chk(paused === 0, "R1", "paused", paused, 0);
    chk(upd === 0 && nv_we === 0 && rf_we === 0, "R1", "strobes", {upd, nv_we, rf_we}, 0);
    rst_n = 1;
    @(negedge clk);

    run(1, "R11", 0);
    chk(nvm[0] === 8'hFF, "R11", "reset list byte", nvm[0], 8'hFF);

    wbuf(0, 8'h02); wbuf(1, 8'h00); wbuf(2, 8'h10);
    wbuf(3, 8'h00); wbuf(4, 8'h01); wbuf(5, 8'h23);
    wbuf(6, 8'h80); wbuf(7, 8'hFF);
    run(1, "R2", 0);

    start_save = 1;
    @(negedge clk);
    start_save = 0;
    chk(busy === 0 && nv_we === 0, "R10", "start in gap", busy, 0);

    for (int i = 0; i < 3; i++) poke_rf(16'h10 + i, 8'h00);
    poke_rf(16'h123, 8'h00);
    run(0, "R6", 0);
    chk(rfm[16'h11] === 8'(16'h11 * 7 + 3), "R6", "restored", rfm[16'h11], 8'(16'h11 * 7 + 3));
    chk(rfm[16'h123] === 8'(16'h123 * 7 + 3), "R3", "restored", rfm[16'h123], 8'(16'h123 * 7 + 3));

    wbuf(0, 8'h01); wbuf(1, 8'h00); wbuf(2, 8'h30); wbuf(3, 8'hFE);
    run(1, "R5", 0);
    wbuf(0, 8'h00); wbuf(1, 8'h02); wbuf(2, 8'h00); wbuf(3, 8'h80); wbuf(4, 8'hFF);
    run(1, "R5", 1);
    run(0, "R6", 0);
    run(1, "R11", 0);

    wbuf(0, 8'h90);
    run(1, "R8", 0);
    for (int i = 0; i < 21; i++) wbuf(i, 8'h80);
    wbuf(21, 8'h00); wbuf(22, 8'h00);
    run(1, "R8", 0);
    for (int i = 21; i < BL; i++) wbuf(i, 8'h80);
    run(1, "R9", 0);

    for (int g = 0; g < 4; g++) begin
      wbuf(g * 3, 8'h7F); wbuf(g * 3 + 1, 8'(g >> 1)); wbuf(g * 3 + 2, 8'(g * 128));
    end
    wbuf(12, 8'hFF);
    run(1, "R7", 0);

    for (int i = 0; i < 512; i++) poke_nv(i, 8'h80);
    run(0, "R7", 0);
    poke_nv(0, 8'h90);
    run(0, "R8", 0);

    wbuf(0, 8'hFF);
    run(1, "R4", 0);
    summary();
  end
endmodule